// File: doc/BRIEF.md
# Storage Test Control and Status Register File

This block sits behind a simple word-addressed register port and holds the parameters for a storage exercise: a 48-bit starting sector address, a 48-bit sector count, a 2-bit operation code and a 3-bit data-pattern choice. Every write is a full 32-bit word. A write to the operation register launches the operation by emitting a single-cycle request to the storage controller. A write that arrives while the controller reports busy changes nothing.

Reads return a snapshot of the controller's and the pattern checker's status through a registered selector with one clock of latency. The read-valid strobe is the read request delayed by one flop. A window of 128 words is set aside for a 512-byte identify-data buffer that lives outside the block. For reads in that window, the block drives the buffer's word address, and the buffer's registered output joins the same one-cycle return path.

Top module: `test_regfile`

## Requirements
- R1: A write to word address 0x000 loads `start_lba[31:0]` from the write data. A write to word 0x001 loads `start_lba[47:32]` from write data bits [15:0], and upper data bits are dropped. The control outputs change only on writes.
- R2: Word 0x002 loads `xfer_len[31:0]` and word 0x003 loads `xfer_len[47:32]` from data bits [15:0], in the same way as R1.
- R3: Word 0x005 loads `patt_sel` from data bits [2:0]. The byte-enable input has no effect on any write, including the all-zero enable.
- R4: A write to word 0x004 while `sts_busy` is low loads `cmd_code` from data bits [1:0] (00 identify, 01 secure erase, 10 write, 11 read). It also raises `cmd_req` for exactly the one cycle that follows the write edge.
- R5: `reg_rd_valid` is high in the cycle after each cycle in which `reg_rd_req` is high, and low otherwise. Read data is valid together with it.
- R6: Word 0x040 reads as the status word: bit0 busy, bit1 error, bit2 verify fail, bits[4:3] link speed (00 none, 01 Gen1, 10 Gen2, 11 Gen3), and zero above that.
- R7: The read-only words are as follows. 0x041 and 0x042 give capacity [31:0] and [47:32]. 0x043 gives the error type. 0x047 gives the test pins. 0x048 and 0x049 give fail byte address [31:0] and [56:32]. 0x04C gives the expected word. 0x050 gives the received word. 0x054 and 0x055 give the byte count [31:0] and [56:32]. The high halves are zero-extended.
- R8: A write to word 0x004 while `sts_busy` is high leaves `cmd_code` unchanged and produces no `cmd_req`.
- R9: Every other word address outside the identify window reads as zero. This includes the six control words.
- R10: Word addresses 0x800 to 0x87F (byte offsets 0x2000 to 0x21FF) make up the identify window. The block drives `iden_rd_addr` with the low 7 word-address bits and returns the buffer's next-cycle output as the read data.
- R11: After reset, all control outputs are zero and `cmd_req` and `reg_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_req | input | 1 | Register read request |
| reg_addr | input | 12 | Word address |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables (ignored) |
| reg_rd_data | output | 32 | Read data, one cycle after request |
| reg_rd_valid | output | 1 | Read data valid |
| start_lba | output | 48 | Start sector address |
| xfer_len | output | 48 | Transfer length in sectors |
| cmd_code | output | 2 | Operation code |
| cmd_req | output | 1 | One-cycle operation launch |
| patt_sel | output | 3 | Test pattern select |
| sts_busy | input | 1 | Controller busy |
| sts_error | input | 1 | Controller error |
| sts_verify_fail | input | 1 | Data verification failed |
| sts_link_speed | input | 2 | Negotiated link speed |
| capacity | input | 48 | Device capacity in sectors |
| err_type | input | 32 | Controller error detail |
| test_pins | input | 32 | Controller debug word |
| fail_addr | input | 57 | First failing byte address |
| exp_word | input | 32 | Expected data at failure |
| got_word | input | 32 | Received data at failure |
| byte_count | input | 57 | Bytes transferred so far |
| iden_rd_addr | output | 7 | Identify buffer word address |
| iden_rd_data | input | 32 | Identify buffer data, one cycle after address |

## Verification
The properties make three assumptions about the inputs. A write and a read never share a cycle. The status inputs are sampled with the request, so their value in the request cycle is the one checked in the following cycle. The identify buffer answers with a registered read of the address it saw on the previous edge. The stimulus holds status inputs steady around every read. It drives write and read strobes only in separate cycles, and it models the buffer as a flop-based lookup of a computed function of its address. With those inputs held, the sweep over all 4096 word addresses can be compared with arithmetic expected values.

// File: rtl/test_regfile_pkg.sv
// Shared constants and types for the test register file.
// Assumes word (32-bit) addressing on the register port.
package test_regfile_pkg;

    localparam int unsigned DATA_W = 32;

    // Control words (writable)
    localparam int unsigned A_LBA_LO  = 'h000;
    localparam int unsigned A_LBA_HI  = 'h001;
    localparam int unsigned A_LEN_LO  = 'h002;
    localparam int unsigned A_LEN_HI  = 'h003;
    localparam int unsigned A_CMD     = 'h004;
    localparam int unsigned A_PATT    = 'h005;

    // Status words (read-only)
    localparam int unsigned A_STATUS  = 'h040;
    localparam int unsigned A_CAP_LO  = 'h041;
    localparam int unsigned A_CAP_HI  = 'h042;
    localparam int unsigned A_ERRTYPE = 'h043;
    localparam int unsigned A_TPINS   = 'h047;
    localparam int unsigned A_FAIL_LO = 'h048;
    localparam int unsigned A_FAIL_HI = 'h049;
    localparam int unsigned A_EXPW    = 'h04C;
    localparam int unsigned A_GOTW    = 'h050;
    localparam int unsigned A_CNT_LO  = 'h054;
    localparam int unsigned A_CNT_HI  = 'h055;

    // Identify buffer window base (word address)
    localparam int unsigned A_IDEN_BASE = 'h800;

    typedef enum logic [1:0] {
        OP_IDENTIFY = 2'b00,
        OP_ERASE    = 2'b01,
        OP_WRITE    = 2'b10,
        OP_READ     = 2'b11
    } op_code_t;

endpackage

// File: rtl/trf_ctrl_regs.sv
// Control register bank: decodes writes into start address, length,
// operation code and pattern select; issues a one-cycle launch pulse.
// Assumes full-word writes; byte enables are not consulted.
module trf_ctrl_regs
    import test_regfile_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LBA_W  = 48,
    parameter int PATT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 busy,
    output logic [LBA_W-1:0]     lba,
    output logic [LBA_W-1:0]     len,
    output op_code_t             op,
    output logic                 launch,
    output logic [PATT_W-1:0]    patt
);

    localparam int HI_W = LBA_W - DATA_W;

    logic [DATA_W-1:0] lba_lo_q, len_lo_q;
    logic [HI_W-1:0]   lba_hi_q, len_hi_q;

    // Purpose: register writes and generate the launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_lo_q <= '0;
            lba_hi_q <= '0;
            len_lo_q <= '0;
            len_hi_q <= '0;
            op       <= OP_IDENTIFY;
            patt     <= '0;
            launch   <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (wr_en) begin
                case (addr)
                    ADDR_W'(A_LBA_LO): lba_lo_q <= wr_data;
                    ADDR_W'(A_LBA_HI): lba_hi_q <= wr_data[HI_W-1:0];
                    ADDR_W'(A_LEN_LO): len_lo_q <= wr_data;
                    ADDR_W'(A_LEN_HI): len_hi_q <= wr_data[HI_W-1:0];
                    ADDR_W'(A_CMD): begin
                        if (!busy) begin
                            op     <= op_code_t'(wr_data[1:0]);
                            launch <= 1'b1;
                        end
                    end
                    ADDR_W'(A_PATT):   patt <= wr_data[PATT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign lba = {lba_hi_q, lba_lo_q};
    assign len = {len_hi_q, len_lo_q};

endmodule

// File: rtl/trf_rd_mux.sv
// Registered read selector: status words and identify-buffer window,
// fixed one-cycle latency. Assumes the identify buffer registers its
// output one cycle after the address it is given.
module trf_rd_mux
    import test_regfile_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int LBA_W   = 48,
    parameter int CNT_W   = 57,
    parameter int IDEN_AW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 busy,
    input  logic                 error,
    input  logic                 vfail,
    input  logic [1:0]           speed,
    input  logic [LBA_W-1:0]     capacity,
    input  logic [DATA_W-1:0]    err_type,
    input  logic [DATA_W-1:0]    test_pins,
    input  logic [CNT_W-1:0]     fail_addr,
    input  logic [DATA_W-1:0]    exp_word,
    input  logic [DATA_W-1:0]    got_word,
    input  logic [CNT_W-1:0]     byte_count,
    input  logic [DATA_W-1:0]    iden_data,
    output logic [IDEN_AW-1:0]   iden_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);

    localparam logic [ADDR_W-1:0] IDEN_BASE = ADDR_W'(A_IDEN_BASE);

    logic              in_iden;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] word_q;
    logic              iden_q;

    // Purpose: detect reads that fall in the identify window.
    assign in_iden   = (addr[ADDR_W-1:IDEN_AW] == IDEN_BASE[ADDR_W-1:IDEN_AW]);
    assign iden_addr = addr[IDEN_AW-1:0];

    // Purpose: pick the status word for the requested address.
    always_comb begin
        case (addr)
            ADDR_W'(A_STATUS):  sel_word = DATA_W'({speed, vfail, error, busy});
            ADDR_W'(A_CAP_LO):  sel_word = capacity[DATA_W-1:0];
            ADDR_W'(A_CAP_HI):  sel_word = DATA_W'(capacity[LBA_W-1:DATA_W]);
            ADDR_W'(A_ERRTYPE): sel_word = err_type;
            ADDR_W'(A_TPINS):   sel_word = test_pins;
            ADDR_W'(A_FAIL_LO): sel_word = fail_addr[DATA_W-1:0];
            ADDR_W'(A_FAIL_HI): sel_word = DATA_W'(fail_addr[CNT_W-1:DATA_W]);
            ADDR_W'(A_EXPW):    sel_word = exp_word;
            ADDR_W'(A_GOTW):    sel_word = got_word;
            ADDR_W'(A_CNT_LO):  sel_word = byte_count[DATA_W-1:0];
            ADDR_W'(A_CNT_HI):  sel_word = DATA_W'(byte_count[CNT_W-1:DATA_W]);
            default:            sel_word = '0;
        endcase
    end

    // Purpose: pipeline stage for data, window flag and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            iden_q   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                word_q <= sel_word;
                iden_q <= in_iden;
            end
        end
    end

    // Purpose: merge the buffer output into the same return stage.
    assign rd_data = iden_q ? iden_data : word_q;

endmodule

// File: rtl/test_regfile.sv
// Top of the storage test register file: control bank plus read path.
// Assumes writes and reads are never requested in the same cycle.
module test_regfile
    import test_regfile_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LBA_W      = 48,
    parameter int CNT_W      = 57,
    parameter int PATT_W     = 3,
    parameter int IDEN_BYTES = 512,
    localparam int IDEN_AW   = $clog2(IDEN_BYTES / 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_req,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wr_data,
    input  logic [3:0]           reg_wr_be,
    output logic [31:0]          reg_rd_data,
    output logic                 reg_rd_valid,
    output logic [LBA_W-1:0]     start_lba,
    output logic [LBA_W-1:0]     xfer_len,
    output logic [1:0]           cmd_code,
    output logic                 cmd_req,
    output logic [PATT_W-1:0]    patt_sel,
    input  logic                 sts_busy,
    input  logic                 sts_error,
    input  logic                 sts_verify_fail,
    input  logic [1:0]           sts_link_speed,
    input  logic [LBA_W-1:0]     capacity,
    input  logic [31:0]          err_type,
    input  logic [31:0]          test_pins,
    input  logic [CNT_W-1:0]     fail_addr,
    input  logic [31:0]          exp_word,
    input  logic [31:0]          got_word,
    input  logic [CNT_W-1:0]     byte_count,
    output logic [IDEN_AW-1:0]   iden_rd_addr,
    input  logic [31:0]          iden_rd_data
);

    op_code_t op_q;

    trf_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .LBA_W  (LBA_W),
        .PATT_W (PATT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wr_data),
        .busy    (sts_busy),
        .lba     (start_lba),
        .len     (xfer_len),
        .op      (op_q),
        .launch  (cmd_req),
        .patt    (patt_sel)
    );

    assign cmd_code = op_q;

    trf_rd_mux #(
        .ADDR_W  (ADDR_W),
        .LBA_W   (LBA_W),
        .CNT_W   (CNT_W),
        .IDEN_AW (IDEN_AW)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (reg_rd_req),
        .addr       (reg_addr),
        .busy       (sts_busy),
        .error      (sts_error),
        .vfail      (sts_verify_fail),
        .speed      (sts_link_speed),
        .capacity   (capacity),
        .err_type   (err_type),
        .test_pins  (test_pins),
        .fail_addr  (fail_addr),
        .exp_word   (exp_word),
        .got_word   (got_word),
        .byte_count (byte_count),
        .iden_data  (iden_rd_data),
        .iden_addr  (iden_rd_addr),
        .rd_data    (reg_rd_data),
        .rd_valid   (reg_rd_valid)
    );

endmodule

// File: rtl/test_regfile_chk.sv
// Property checker for test_regfile, attached by bind below.
// Assumes status inputs are sampled in the request cycle.
module test_regfile_chk #(
    parameter int ADDR_W  = 12,
    parameter int LBA_W   = 48,
    parameter int PATT_W  = 3,
    parameter int IDEN_AW = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic                 reg_rd_req,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [31:0]          reg_wr_data,
    input logic [3:0]           reg_wr_be,
    input logic [31:0]          reg_rd_data,
    input logic                 reg_rd_valid,
    input logic [LBA_W-1:0]     start_lba,
    input logic [LBA_W-1:0]     xfer_len,
    input logic [1:0]           cmd_code,
    input logic                 cmd_req,
    input logic [PATT_W-1:0]    patt_sel,
    input logic                 sts_busy,
    input logic                 sts_error,
    input logic                 sts_verify_fail,
    input logic [1:0]           sts_link_speed,
    input logic [IDEN_AW-1:0]   iden_rd_addr
);

    logic wr_cmd, wr_patt, rd_status, rd_hole, rd_iden;
    assign wr_cmd    = reg_wr_en && (reg_addr == ADDR_W'('h004));
    assign wr_patt   = reg_wr_en && (reg_addr == ADDR_W'('h005));
    assign rd_status = reg_rd_req && (reg_addr == ADDR_W'('h040));
    assign rd_hole   = reg_rd_req && (reg_addr == ADDR_W'('h006));
    assign rd_iden   = reg_rd_req && (reg_addr[ADDR_W-1:IDEN_AW] == 5'b10000);

    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ($stable(start_lba) && $stable(xfer_len) && $stable(patt_sel) && $stable(cmd_code)));

    p_patt_no_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_patt && reg_wr_be != 4'hF) |=> patt_sel == $past(reg_wr_data[PATT_W-1:0]));

    p_cmd_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !sts_busy) |=> (cmd_req && cmd_code == $past(reg_wr_data[1:0])));

    p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    p_rd_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> reg_rd_valid);

    p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_req |=> !reg_rd_valid);

    p_status_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> reg_rd_data == {27'd0, $past(sts_link_speed), $past(sts_verify_fail),
                                      $past(sts_error), $past(sts_busy)});

    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && sts_busy) |=> (!cmd_req && $stable(cmd_code)));

    p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hole |=> reg_rd_data == 32'd0);

    p_iden_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_iden |-> iden_rd_addr == reg_addr[IDEN_AW-1:0]);

endmodule

bind test_regfile test_regfile_chk #(
    .ADDR_W  (ADDR_W),
    .LBA_W   (LBA_W),
    .PATT_W  (PATT_W),
    .IDEN_AW (IDEN_AW)
) u_chk (.*);

// File: tb/test_regfile_tb.sv
module test_regfile_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_req = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_wr_be = 4'hF;
    logic [31:0] reg_rd_data;
    logic        reg_rd_valid;
    logic [47:0] start_lba, xfer_len;
    logic [1:0]  cmd_code;
    logic        cmd_req;
    logic [2:0]  patt_sel;
    logic        sts_busy = 1'b0, sts_error = 1'b0, sts_verify_fail = 1'b0;
    logic [1:0]  sts_link_speed = 2'b00;
    logic [47:0] capacity   = 48'h9A3C_1234_5678;
    logic [31:0] err_type   = 32'hDEAD_0042;
    logic [31:0] test_pins  = 32'h0F1E_2D3C;
    logic [56:0] fail_addr  = 57'h0AB_CDEF_0123_4567;
    logic [31:0] exp_word   = 32'h1357_9BDF;
    logic [31:0] got_word   = 32'h2468_ACE0;
    logic [56:0] byte_count = 57'h1F0_0000_1111_2222;
    logic [6:0]  iden_rd_addr;
    logic [31:0] iden_rd_data = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    test_regfile u_dut (.*);

    // Identify buffer model: registered lookup of a computed word.
    function automatic logic [31:0] iden_word(input logic [6:0] a);
        return {8'hA5, 1'b0, a, ~a, 1'b1, 8'(a * 3)};
    endfunction

    always_ff @(posedge clk) iden_rd_data <= iden_word(iden_rd_addr);

    function automatic logic [31:0] exp_read(input int a);
        if (a >= 'h800 && a <= 'h87F) return iden_word(7'(a));
        case (a)
            'h040: return {27'd0, sts_link_speed, sts_verify_fail, sts_error, sts_busy};
            'h041: return capacity[31:0];
            'h042: return {16'd0, capacity[47:32]};
            'h043: return err_type;
            'h047: return test_pins;
            'h048: return fail_addr[31:0];
            'h049: return {7'd0, fail_addr[56:32]};
            'h04C: return exp_word;
            'h050: return got_word;
            'h054: return byte_count[31:0];
            'h055: return {7'd0, byte_count[56:32]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d; reg_wr_be = be;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_be = 4'hF;
    endtask

    task automatic rd(input int a, input string req);
        logic [31:0] e;
        @(negedge clk);
        reg_rd_req = 1'b1; reg_addr = 12'(a);
        e = exp_read(a);
        @(negedge clk);
        reg_rd_req = 1'b0;
        check(reg_rd_data === e && reg_rd_valid === 1'b1, req, {31'd0, reg_rd_valid, reg_rd_data}, {32'd1, e});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(start_lba == 0 && xfer_len == 0 && cmd_code == 0 && patt_sel == 0, "R11",
              {start_lba[31:0], xfer_len[31:0]}, 64'd0);
        check(!cmd_req && !reg_rd_valid, "R11", {cmd_req, reg_rd_valid}, 0);
        rst_n = 1'b1;

        // R1: start address halves, upper data bits dropped
        wr(12'h000, 32'h89AB_CDEF, 4'hF);
        wr(12'h001, 32'hFFFF_5A5A, 4'hF);
        check(start_lba == 48'h5A5A_89AB_CDEF, "R1", start_lba, 48'h5A5A_89AB_CDEF);
        // R2: length halves with zero byte enables (R3 also)
        wr(12'h002, 32'h0000_1000, 4'h0);
        wr(12'h003, 32'h1234_0077, 4'h0);
        check(xfer_len == 48'h0077_0000_1000, "R2", xfer_len, 48'h0077_0000_1000);
        // R3: pattern select, byte enables ignored
        wr(12'h005, 32'hFFFF_FFFD, 4'h0);
        check(patt_sel == 3'b101, "R3", patt_sel, 3'b101);
        wr(12'h005, 32'h0000_0002, 4'h1);
        check(patt_sel == 3'b010, "R3", patt_sel, 3'b010);
        check(start_lba == 48'h5A5A_89AB_CDEF, "R1 hold", start_lba, 48'h5A5A_89AB_CDEF);

        // R4: every operation code launches a single pulse
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            reg_wr_en = 1'b1; reg_addr = 12'h004; reg_wr_data = 32'hFFFF_FFF0 | 32'(c);
            @(negedge clk);
            reg_wr_en = 1'b0;
            check(cmd_req === 1'b1 && cmd_code == 2'(c), "R4", {cmd_req, cmd_code}, {1'b1, 2'(c)});
            @(negedge clk);
            check(cmd_req === 1'b0, "R4 width", cmd_req, 0);
        end

        // R8: command write while busy is ignored
        sts_busy = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h004; reg_wr_data = 32'h1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(cmd_req === 1'b0 && cmd_code == 2'b11, "R8", {cmd_req, cmd_code}, {1'b0, 2'b11});
        @(negedge clk);
        check(cmd_req === 1'b0, "R8", cmd_req, 0);
        sts_busy = 1'b0;

        // R6: all status bit combinations
        for (int s = 0; s < 32; s++) begin
            {sts_link_speed, sts_verify_fail, sts_error, sts_busy} = 5'(s);
            rd('h040, "R6");
        end
        {sts_link_speed, sts_verify_fail, sts_error, sts_busy} = 5'd0;

        // R5: valid drops when no request follows
        rd('h043, "R7");
        check(reg_rd_valid === 1'b1, "R5", reg_rd_valid, 1);
        @(negedge clk);
        check(reg_rd_valid === 1'b0, "R5", reg_rd_valid, 0);

        // R7, R9, R10: sweep every word address
        for (int a = 0; a < 4096; a++) begin
            if (a >= 'h800 && a <= 'h87F) rd(a, "R10");
            else if (exp_read(a) != 0 || a == 'h040) rd(a, "R7");
            else rd(a, "R9");
        end

        // R5: back-to-back reads keep valid high
        @(negedge clk);
        reg_rd_req = 1'b1; reg_addr = 12'h041;
        @(negedge clk);
        reg_addr = 12'h812;
        check(reg_rd_valid === 1'b1 && reg_rd_data == capacity[31:0], "R5", reg_rd_data, capacity[31:0]);
        @(negedge clk);
        reg_rd_req = 1'b0;
        check(reg_rd_valid === 1'b1 && reg_rd_data == iden_word(7'h12), "R10", reg_rd_data, iden_word(7'h12));
        @(negedge clk);
        check(reg_rd_valid === 1'b0, "R5", reg_rd_valid, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule